// File: doc/BRIEF.md
# Bus Error Code Capture Unit

This block sits beside the bit-stream processor of a CAN controller. When that processor reports a bus error, the block stores three things in one 8-bit capture word: the kind of error, whether the node was receiving, and the 5-bit code of the frame segment where the fault was seen. In the same step it raises a bus-error interrupt flag, if the host has enabled that interrupt.

The first capture freezes the word. Later errors change nothing until the host reads the capture word once, and that read re-arms capture. While a capture is still unread, no further bus-error interrupt can be raised. The host clears the flag by reading the interrupt register.

Both registers are seen through one small read port. The address picks the register, the read data is combinational, and the side effects of a read take hold at the clock edge that ends the read cycle.

Top module: `bus_err_capture`

## Requirements
- R1: After reset the capture word reads 0x00, the interrupt register reads 0x00, `irq` is low, and capture is armed, so the first error strobe is accepted.
- R2: An error strobe accepted while armed makes the capture word, from the next cycle on, equal to {err_kind[1:0], err_rx, err_seg[4:0]}. Bits 7:6 hold the kind (00 bit, 01 form, 10 stuff, 11 other), bit 5 holds the direction (1 = receive) and bits 4:0 hold the segment code. Every one of the 32 segment codes passes through unchanged.
- R3: An accepted strobe with `int_en` high sets `irq` in the next cycle.
- R4: Once captured, the word keeps its value through any number of further strobes until the host reads address 0.
- R5: A strobe that arrives while a capture is unread and no capture read is in progress does not set `irq`.
- R6: A read at address 1 returns 0x80 while the flag is set (flag in bit 7, all other bits 0), and the flag is clear from the next cycle on.
- R7: When a strobe comes in the same cycle as a capture read, the read returns the old word and the new error is captured, visible in the next cycle. `irq` is set if it is enabled.
- R8: When a capture and an interrupt-register read fall in the same cycle, setting wins and `irq` is high in the next cycle.
- R9: A capture taken with `int_en` low leaves `irq` low, and turning `int_en` on afterwards does not raise it.
- R10: A capture read re-arms the unit, so the next strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_strobe | input | 1 | Bus error seen by the bit-stream processor in this cycle |
| err_seg | input | 5 | Frame-segment code at the time of the error |
| err_kind | input | 2 | Error kind: 00 bit, 01 form, 10 stuff, 11 other |
| err_rx | input | 1 | 1 when the node was receiving |
| int_en | input | 1 | Bus-error interrupt enable |
| rd_en | input | 1 | Host read strobe; read side effects apply at the next edge |
| rd_addr | input | 1 | 0 selects the capture word, 1 selects the interrupt register |
| rd_data | output | 8 | Contents of the selected register |
| irq | output | 1 | Bus-error interrupt flag |

## Verification
The bench builds the unit with its default flag position, bit 7 of the interrupt register. With that setting the whole capture-word space is small enough to cover completely. It sweeps all 32 segment codes against all four error kinds and both directions, which reaches every bit of the word layout. Directed sequences then cover the same-cycle collisions: a strobe during a capture read, and a capture during an interrupt read. A long pseudo-random phase follows, in which a bench model built from the requirements predicts the read data and the flag in every cycle.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int SEG_W  = 5;
  localparam int KIND_W = 2;
  localparam int WORD_W = KIND_W + 1 + SEG_W;

  localparam logic ADDR_CAP = 1'b0;
  localparam logic ADDR_INT = 1'b1;

  typedef enum logic [KIND_W-1:0] {
    KIND_BIT   = 2'b00,
    KIND_FORM  = 2'b01,
    KIND_STUFF = 2'b10,
    KIND_OTHER = 2'b11
  } err_kind_e;

  typedef enum logic [SEG_W-1:0] {
    SEG_SOF        = 5'b00011,
    SEG_ID_A       = 5'b00010,
    SEG_ID_B       = 5'b00110,
    SEG_SUBST_RTR  = 5'b00100,
    SEG_EXT_FLAG   = 5'b00101,
    SEG_ID_C       = 5'b00111,
    SEG_ID_D       = 5'b01111,
    SEG_ID_E       = 5'b01110,
    SEG_RTR        = 5'b01100,
    SEG_RSV1       = 5'b01101,
    SEG_RSV0       = 5'b01001,
    SEG_DLC        = 5'b01011,
    SEG_DATA       = 5'b01010,
    SEG_CRC        = 5'b01000,
    SEG_CRC_DELIM  = 5'b11000,
    SEG_ACK_SLOT   = 5'b11001,
    SEG_ACK_DELIM  = 5'b11011,
    SEG_EOF        = 5'b11010,
    SEG_IFS        = 5'b10010,
    SEG_ACT_EFLAG  = 5'b10001,
    SEG_PAS_EFLAG  = 5'b10110,
    SEG_TOL_DOM    = 5'b10011,
    SEG_ERR_DELIM  = 5'b10111,
    SEG_OVLD_FLAG  = 5'b11100
  } seg_pos_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic              rx;
    logic [SEG_W-1:0]  seg;
  } cap_word_t;
endpackage

// File: rtl/bec_rst_sync.sv
module bec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bec_capture.sv
module bec_capture
  import bec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      err_strobe,
  input  cap_word_t err_word,
  input  logic      host_rd_cap,
  output cap_word_t cap_word,
  output logic      armed,
  output logic      cap_take
);
  logic armed_d;
  logic armed_en;

  // A read of the capture word re-arms in the same cycle, so a strobe that
  // collides with the read is taken at the edge that ends the read.
  always_comb begin
    cap_take = err_strobe & (armed | host_rd_cap);
    armed_en = cap_take | host_rd_cap;
    armed_d  = ~cap_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word <= '0;
    end else if (cap_take) begin
      cap_word <= err_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (armed_en) begin
      armed <= armed_d;
    end
  end
endmodule

// File: rtl/bec_irq_flag.sv
module bec_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_take,
  input  logic int_en,
  input  logic host_rd_int,
  output logic flag
);
  logic set_req;
  logic flag_en;
  logic flag_d;

  // Setting has priority over the clear-on-read.
  always_comb begin
    set_req = cap_take & int_en;
    flag_en = set_req | host_rd_int;
    flag_d  = set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_en) begin
      flag <= flag_d;
    end
  end
endmodule

// File: rtl/bec_read_mux.sv
module bec_read_mux
  import bec_pkg::*;
#(
  parameter int INT_BIT = WORD_W - 1
) (
  input  logic              rd_addr,
  input  cap_word_t         cap_word,
  input  logic              flag,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] int_reg;

  for (genvar i = 0; i < WORD_W; i++) begin : g_int_bits
    if (i == INT_BIT) begin : g_flag
      assign int_reg[i] = flag;
    end else begin : g_zero
      assign int_reg[i] = 1'b0;
    end
  end

  always_comb begin
    if (rd_addr == ADDR_INT) rd_data = int_reg;
    else                     rd_data = cap_word;
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int INT_BIT = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_strobe,
  input  logic [SEG_W-1:0]  err_seg,
  input  logic [KIND_W-1:0] err_kind,
  input  logic              err_rx,
  input  logic              int_en,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  logic      rst_i_n;
  cap_word_t err_word;
  cap_word_t cap_word;
  logic      armed;
  logic      cap_take;
  logic      host_rd_cap;
  logic      host_rd_int;

  assign err_word    = '{kind: err_kind, rx: err_rx, seg: err_seg};
  assign host_rd_cap = rd_en & (rd_addr == ADDR_CAP);
  assign host_rd_int = rd_en & (rd_addr == ADDR_INT);

  bec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bec_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .err_strobe  (err_strobe),
    .err_word    (err_word),
    .host_rd_cap (host_rd_cap),
    .cap_word    (cap_word),
    .armed       (armed),
    .cap_take    (cap_take)
  );

  bec_irq_flag u_irq (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .cap_take    (cap_take),
    .int_en      (int_en),
    .host_rd_int (host_rd_int),
    .flag        (irq)
  );

  bec_read_mux #(.INT_BIT(INT_BIT)) u_rd (
    .rd_addr  (rd_addr),
    .cap_word (cap_word),
    .flag     (irq),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/bec_checker.sv
module bec_checker
  import bec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              err_strobe,
  input logic [SEG_W-1:0]  err_seg,
  input logic [KIND_W-1:0] err_kind,
  input logic              err_rx,
  input logic              int_en,
  input logic              rd_en,
  input logic              rd_addr,
  input logic [WORD_W-1:0] cap_word,
  input logic              armed,
  input logic              irq
);
  logic rd_cap;
  logic rd_int;
  logic accept;
  assign rd_cap = rd_en & (rd_addr == ADDR_CAP);
  assign rd_int = rd_en & (rd_addr == ADDR_INT);
  assign accept = err_strobe & (armed | rd_cap);

  // R2, R7: an accepted strobe loads the word in the field layout
  a_r2_word_layout: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cap_word == {$past(err_kind), $past(err_rx), $past(err_seg)});

  // R4: with capture pending and no capture read, the word is frozen
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !rd_cap) |=> $stable(cap_word));

  // R3: accepted strobe with enable sets the flag
  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && int_en) |=> irq);

  // R5: no new interrupt without an accepted strobe
  a_r5_no_new_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(accept && int_en)) |=> !irq);

  // R6: interrupt-register read clears unless a set coincides
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_int && !(accept && int_en)) |=> !irq);

  // R10: a capture read without a strobe leaves the unit armed
  a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cap && !err_strobe) |=> armed);
endmodule

bind bus_err_capture bec_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .err_strobe (err_strobe),
  .err_seg    (err_seg),
  .err_kind   (err_kind),
  .err_rx     (err_rx),
  .int_en     (int_en),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .cap_word   (cap_word),
  .armed      (armed),
  .irq        (irq)
);

// File: tb/tb_bus_err_capture.sv
`timescale 1ns/1ps
module tb_bus_err_capture;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       err_strobe;
  logic [4:0] err_seg;
  logic [1:0] err_kind;
  logic       err_rx;
  logic       int_en;
  logic       rd_en;
  logic       rd_addr;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rd;
  logic       last_irq;
  logic [7:0] m_cap;
  logic       m_armed;
  logic       m_flag;

  always #10 clk = ~clk;

  bus_err_capture dut (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_seg(err_seg),
    .err_kind(err_kind), .err_rx(err_rx), .int_en(int_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, sample read data before the
  // rising edge, sample irq after it.
  task automatic cyc(input logic s, input logic [4:0] sg, input logic [1:0] k,
                     input logic rx, input logic en, input logic re, input logic ad);
    err_strobe = s; err_seg = sg; err_kind = k; err_rx = rx;
    int_en = en; rd_en = re; rd_addr = ad;
    #2 last_rd = rd_data;
    @(posedge clk);
    @(negedge clk);
    last_irq = irq;
    err_strobe = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; err_strobe = 0; err_seg = 0; err_kind = 0; err_rx = 0;
    int_en = 0; rd_en = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cyc(0, 0, 0, 0, 1, 1, 0);
    check("R1 capture", last_rd, 8'h00);
    check("R1 irq", {7'd0, last_irq}, 8'h00);
    cyc(0, 0, 0, 0, 1, 1, 1);
    check("R1 intreg", last_rd, 8'h00);
    // R3 first capture with enable
    cyc(1, 5'h0A, 2'd2, 1, 1, 0, 0);
    check("R3 irq set", {7'd0, last_irq}, 8'h01);
    // R4 later strobe while pending is ignored
    cyc(1, 5'h03, 2'd0, 0, 1, 0, 0);
    // R6 interrupt read returns 0x80 and clears
    cyc(0, 0, 0, 0, 1, 1, 1);
    check("R6 intreg", last_rd, 8'h80);
    check("R6 cleared", {7'd0, last_irq}, 8'h00);
    // R5 strobe while pending raises nothing
    cyc(1, 5'h11, 2'd1, 0, 1, 0, 0);
    check("R5 no irq", {7'd0, last_irq}, 8'h00);
    // R4 word held; read re-arms (R10)
    cyc(0, 0, 0, 0, 1, 1, 0);
    check("R4 held word", last_rd, 8'hAA);
    // R9 capture with enable off
    cyc(1, 5'h1C, 2'd3, 1, 0, 0, 0);
    check("R9 irq off", {7'd0, last_irq}, 8'h00);
    cyc(0, 0, 0, 0, 1, 0, 0);
    check("R9 late enable", {7'd0, last_irq}, 8'h00);
    // R7 strobe during capture read
    cyc(1, 5'h19, 2'd0, 1, 1, 1, 0);
    check("R7 old word", last_rd, 8'hFC);
    check("R7 irq", {7'd0, last_irq}, 8'h01);
    cyc(0, 0, 0, 0, 1, 1, 1);
    check("R6 clear again", {7'd0, last_irq}, 8'h00);
    cyc(0, 0, 0, 0, 1, 1, 0);
    check("R7 new word", last_rd, 8'h39);
    // R8 capture and interrupt read together
    cyc(1, 5'h12, 2'd2, 0, 1, 1, 1);
    check("R8 read value", last_rd, 8'h00);
    check("R8 set wins", {7'd0, last_irq}, 8'h01);
    cyc(0, 0, 0, 0, 1, 1, 0);
    check("R10 rearmed capture", last_rd, 8'h92);
    cyc(0, 0, 0, 0, 1, 1, 1);

    // R2 sweep over all segment codes, kinds and directions
    for (int sg = 0; sg < 32; sg++) begin
      for (int k = 0; k < 4; k++) begin
        for (int rx = 0; rx < 2; rx++) begin
          cyc(1, 5'(sg), 2'(k), 1'(rx), 1, 0, 0);
          check("R3 sweep irq", {7'd0, last_irq}, 8'h01);
          cyc(0, 0, 0, 0, 1, 1, 0);
          check("R2 sweep word", last_rd, 8'((k << 6) | (rx << 5) | sg));
          cyc(0, 0, 0, 0, 1, 1, 1);
          check("R6 sweep clear", {7'd0, last_irq}, 8'h00);
        end
      end
    end

    // Pseudo-random phase against a model of the requirements
    m_cap = 8'hFF; m_armed = 1'b1; m_flag = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      logic s, en, re, ad, take;
      logic [4:0] sg;
      logic [1:0] k;
      logic rx;
      logic [7:0] exp_rd;
      s = ($urandom % 2) == 0; en = ($urandom % 4) != 0;
      re = ($urandom % 3) == 0; ad = 1'($urandom);
      sg = 5'($urandom); k = 2'($urandom); rx = 1'($urandom);
      exp_rd = ad ? {m_flag, 7'd0} : m_cap;
      take = s && (m_armed || (re && !ad));
      cyc(s, sg, k, rx, en, re, ad);
      check(ad ? "R6 random intreg" : "R4 random capture", last_rd, exp_rd);
      if (take) begin
        m_cap = {k, rx, sg}; m_armed = 1'b0;
      end else if (re && !ad) begin
        m_armed = 1'b1;
      end
      if (take && en) m_flag = 1'b1;
      else if (re && ad) m_flag = 1'b0;
      check("R5 random irq", {7'd0, last_irq}, {7'd0, m_flag});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule